// File: doc/BRIEF.md
# SHA-1 Four-Round Compression Unit

This unit advances a SHA-1 working state by four compression rounds per operation. A caller presents the packed A, B, C and D words on one 128-bit operand, four schedule words on a second 128-bit operand, and a 2-bit round-group code. The code chooses the logic function and the additive constant. The unit performs one round per clock and then raises `done` for a single cycle, with the new packed state on `state_out`.

The fifth state word E enters the group as zero. A caller that needs a non-zero E folds it into the first schedule word before starting. E propagation between groups, message schedule expansion and the final digest addition all belong to neighbouring logic.

Top module: `sha1q_unit`

## Requirements
- R1: A synchronous active-low reset, whether applied while idle or in the middle of an operation, leaves `busy` and `done` low and `state_out` all zero.
- R2: `start` sampled high while `busy` is low begins an operation, and `busy` is high in the following cycle. `done` rises at the fourth rising edge after the edge that accepted `start`.
- R3: `done` is high for exactly one cycle per operation, and `busy` is low in that cycle.
- R4: `start` sampled while `busy` is high is ignored. The running operation keeps its operands, its code and its timing.
- R5: Code 0 uses the choose function (B&C)^(~B&D) and the constant 0x5A827999.
- R6: Code 1 uses the parity function B^C^D and the constant 0x6ED9EBA1.
- R7: Code 2 uses the majority function (B&C)^(B&D)^(C&D) and the constant 0x8F1BBCDC.
- R8: Code 3 uses the parity function B^C^D and the constant 0xCA62C1D6.
- R9: Operand packing is A = `state_in[127:96]`, B = `[95:64]`, C = `[63:32]` and D = `[31:0]`, and E starts at zero.
  - Round i (0..3) uses schedule word `msg_in[127-32i -: 32]`.
  - Each round computes newA = f(B,C,D) + rol5(A) + W + E + K, then shifts E←D, D←C, C←rol30(B), B←A, A←newA.
  - After four rounds `state_out` holds A, B, C and D in the same lane positions as the input.
- R10: `func_sel` is captured when `start` is accepted. Later changes to it during the operation have no effect on the result.
- R11: After `done`, `state_out` keeps the result until the next accepted `start`, whatever the other inputs do.
- R12: All additions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| state_in | input | 128 | Packed A..D working state |
| msg_in | input | 128 | Four schedule words, lane 3 used first |
| func_sel | input | 2 | Round-group code (function and constant) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| state_out | output | 128 | Packed A..D after four rounds |

## Verification
The assertions rely on only one property of the environment: `rst_n` is held low from time zero until the first edges have passed. Beyond that they treat `start` as completely free, including pulses that arrive while the unit is busy and in the same cycle that `done` is high.

The bench drives every input half a period away from the sampling edge. It deliberately raises `start` in the middle of operations with different operands and a different code, so the ignore and latch requirements are exercised inside the space the properties cover. Operand patterns include all zeros, all ones (to force carries out of every adder), alternating bits and pseudo-random words, and each pattern is run with every code.

// File: rtl/sha1q_pkg.sv
// Shared constants and helpers for the four-round SHA-1 unit.
// Assumes 32-bit words; the round constants are defined at that width.
package sha1q_pkg;
    localparam int WORD_W   = 32;
    localparam int LANES    = 4;
    localparam int ROUNDS   = 4;
    localparam int CODE_W   = 2;

    typedef enum logic [CODE_W-1:0] {
        FN_CHOOSE = 2'd0,
        FN_PAR_A  = 2'd1,
        FN_MAJ    = 2'd2,
        FN_PAR_B  = 2'd3
    } fn_code_e;

    // Additive constant for a round-group code.
    function automatic logic [WORD_W-1:0] round_const(input fn_code_e code);
        case (code)
            FN_CHOOSE: round_const = 32'h5A82_7999;
            FN_PAR_A:  round_const = 32'h6ED9_EBA1;
            FN_MAJ:    round_const = 32'h8F1B_BCDC;
            default:   round_const = 32'hCA62_C1D6;
        endcase
    endfunction
endpackage

// File: rtl/sha1q_logic_fn.sv
// Combinational SHA-1 round logic function selected by the group code.
// Assumes the code is stable for the whole operation (latched upstream).
module sha1q_logic_fn
    import sha1q_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    input  fn_code_e     code,
    output logic [W-1:0] f
);
    // Pick choose, parity or majority by code.
    always_comb begin
        case (code)
            FN_CHOOSE: f = (b & c) ^ (~b & d);
            FN_MAJ:    f = (b & c) ^ (b & d) ^ (c & d);
            default:   f = b ^ c ^ d;
        endcase
    end
endmodule

// File: rtl/sha1q_round.sv
// One SHA-1 compression round: computes the new A and the shifted state.
// Assumes W >= 31 so the fixed rotations are well formed.
module sha1q_round
    import sha1q_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] e_i,
    input  logic [W-1:0] w_i,
    input  fn_code_e     code,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] c_o,
    output logic [W-1:0] d_o,
    output logic [W-1:0] e_o
);
    logic [W-1:0] fval;
    logic [W-1:0] a_rot5;
    logic [W-1:0] b_rot30;
    logic [W-1:0] kval;

    sha1q_logic_fn #(.W(W)) u_fn (
        .b(b_i), .c(c_i), .d(d_i), .code(code), .f(fval)
    );

    // Fixed rotations and the group constant.
    always_comb begin
        a_rot5  = {a_i[W-6:0], a_i[W-1:W-5]};
        b_rot30 = {b_i[1:0], b_i[W-1:2]};
        kval    = round_const(code);
    end

    // Five-term sum (wraps at W bits) and the state shift.
    always_comb begin
        a_o = fval + a_rot5 + w_i + e_i + kval;
        b_o = a_i;
        c_o = b_rot30;
        d_o = c_i;
        e_o = d_i;
    end
endmodule

// File: rtl/sha1q_seq.sv
// Operation sequencer: accepts start when idle, counts ROUNDS steps,
// then pulses done for one cycle. Ignores start while busy.
module sha1q_seq #(
    parameter int ROUNDS = sha1q_pkg::ROUNDS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    logic [CNT_W-1:0] cnt;

    // Strobes to the datapath.
    always_comb begin
        load = start && !busy;
        step = busy;
    end

    // Busy flag, round counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                end
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sha1q_unit.sv
// Four-round SHA-1 compression unit. Loads packed A..D, four schedule
// words and a group code on start, runs one round per clock, pulses done.
// Assumes E is pre-folded into the first schedule word by the caller.
module sha1q_unit
    import sha1q_pkg::*;
#(
    parameter int WORD_W_P = WORD_W,
    parameter int LANES_P  = LANES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [WORD_W_P*LANES_P-1:0] state_in,
    input  logic [WORD_W_P*LANES_P-1:0] msg_in,
    input  logic [CODE_W-1:0]           func_sel,
    output logic                        busy,
    output logic                        done,
    output logic [WORD_W_P*LANES_P-1:0] state_out
);
    localparam int W   = WORD_W_P;
    localparam int VEC = WORD_W_P * LANES_P;

    logic [W-1:0] in_lane [LANES_P];
    logic [W-1:0] reg_a, reg_b, reg_c, reg_d, reg_e;
    logic [W-1:0] nxt_a, nxt_b, nxt_c, nxt_d, nxt_e;
    logic [VEC-1:0] msg_q;
    fn_code_e       code_q;
    logic           load, step;

    // Slice the packed state operand into lanes.
    for (genvar g = 0; g < LANES_P; g++) begin : g_lane
        assign in_lane[g] = state_in[g*W +: W];
    end

    sha1q_seq #(.ROUNDS(ROUNDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .step(step), .busy(busy), .done(done)
    );

    sha1q_round #(.W(W)) u_round (
        .a_i(reg_a), .b_i(reg_b), .c_i(reg_c), .d_i(reg_d), .e_i(reg_e),
        .w_i(msg_q[VEC-1 -: W]), .code(code_q),
        .a_o(nxt_a), .b_o(nxt_b), .c_o(nxt_c), .d_o(nxt_d), .e_o(nxt_e)
    );

    // Working state, schedule shift register and latched group code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a  <= '0;
            reg_b  <= '0;
            reg_c  <= '0;
            reg_d  <= '0;
            reg_e  <= '0;
            msg_q  <= '0;
            code_q <= FN_CHOOSE;
        end else if (load) begin
            reg_a  <= in_lane[3];
            reg_b  <= in_lane[2];
            reg_c  <= in_lane[1];
            reg_d  <= in_lane[0];
            reg_e  <= '0;
            msg_q  <= msg_in;
            code_q <= fn_code_e'(func_sel);
        end else if (step) begin
            reg_a  <= nxt_a;
            reg_b  <= nxt_b;
            reg_c  <= nxt_c;
            reg_d  <= nxt_d;
            reg_e  <= nxt_e;
            msg_q  <= msg_q << W;
        end
    end

    // Packed result, lane 3 = A down to lane 0 = D.
    assign state_out = {reg_a, reg_b, reg_c, reg_d};
endmodule

// File: rtl/sha1q_unit_chk.sv
// Protocol checker for sha1q_unit; attached by bind below.
// Assumes rst_n is low from time zero through the first edges.
module sha1q_unit_chk #(
    parameter int VEC = 128
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [VEC-1:0] state_out
);
    logic [2:0] run_len;

    // Count cycles spent busy in the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r2_four_rounds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len == 3'd3) |=> (done && !busy));
    a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len < 3'd4);
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len != 3'd3) |=> busy);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(state_out));
endmodule

bind sha1q_unit sha1q_unit_chk #(.VEC(WORD_W_P*LANES_P)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .state_out(state_out)
);

// File: tb/sha1q_unit_tb.sv
// Self-checking bench for sha1q_unit: sweeps every code over several
// operand patterns against an arithmetic model written from the brief.
module sha1q_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] state_in = '0;
    logic [127:0] msg_in = '0;
    logic [1:0]   func_sel = '0;
    logic         busy, done;
    logic [127:0] state_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sha1q_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
        .msg_in(msg_in), .func_sel(func_sel), .busy(busy), .done(done),
        .state_out(state_out)
    );

    function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
        logic [63:0] dbl = {x, x};
        return dbl[63-n -: 32];
    endfunction

    // Model of four rounds (R5..R9, R12), built from the requirement text.
    function automatic logic [127:0] model(input logic [127:0] s,
                                           input logic [127:0] m,
                                           input logic [1:0] k);
        logic [31:0] a = s[127:96], b = s[95:64], c = s[63:32], d = s[31:0];
        logic [31:0] e = 0, f, kc, t;
        kc = (k == 0) ? 32'h5A827999 : (k == 1) ? 32'h6ED9EBA1 :
             (k == 2) ? 32'h8F1BBCDC : 32'hCA62C1D6;
        for (int i = 0; i < 4; i++) begin
            if (k == 0)      f = (b & c) | (~b & d);
            else if (k == 2) f = (b & c) | (b & d) | (c & d);
            else             f = b ^ c ^ d;
            t = f + rotl(a, 5) + m[127-32*i -: 32] + e + kc;
            e = d; d = c; c = rotl(b, 30); b = a; a = t;
        end
        return {a, b, c, d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    // Run one operation; disturb raises start with other operands mid-run.
    task automatic run_op(input logic [127:0] s, input logic [127:0] m,
                          input logic [1:0] k, input bit disturb,
                          input string req);
        int lat;
        logic [127:0] exp;
        exp = model(s, m, k);
        @(negedge clk);
        state_in = s; msg_in = m; func_sel = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", 128'(busy), 128'd1);
        lat = 1;
        while (!done && lat < 12) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 2) begin
                start = 1'b1; state_in = ~s; msg_in = ~m; func_sel = k ^ 2'd1;
            end else begin
                start = 1'b0;
            end
        end
        chk(lat == 5, "R2 done latency", 128'(lat), 128'd5);
        chk(state_out == exp, req, state_out, exp);
        chk(busy == 1'b0, "R3 busy low with done", 128'(busy), 128'd0);
        @(negedge clk);
        chk(done == 1'b0, "R3 done one cycle", 128'(done), 128'd0);
    endtask

    initial begin
        logic [31:0] seed = 32'h1234_5677;
        logic [127:0] s, m, exp;
        string req;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
        chk(state_out == 0, "R1 reset state", state_out, 0);
        rst_n = 1'b1;

        for (int k = 0; k < 4; k++) begin
            req = (k == 0) ? "R5 choose" : (k == 1) ? "R6 parity" :
                  (k == 2) ? "R7 majority" : "R8 parity";
            for (int p = 0; p < 6; p++) begin
                case (p)
                    0: begin s = '0; m = '0; end
                    1: begin s = '1; m = '1; end
                    2: begin s = {4{32'hAAAA5555}}; m = {4{32'h0F0F_F0F0}}; end
                    default: begin
                        for (int j = 0; j < 4; j++) begin
                            seed = xs(seed); s[j*32 +: 32] = seed;
                            seed = xs(seed); m[j*32 +: 32] = seed;
                        end
                    end
                endcase
                run_op(s, m, 2'(k), 1'b0, (p == 1) ? "R12 wrap" : req);
            end
        end

        // R9: distinct lane values expose packing and word order.
        run_op({32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210},
               {32'h1, 32'h20, 32'h300, 32'h4000}, 2'd1, 1'b0, "R9 packing");

        // R4 and R10: start, operands and code disturbed mid-run.
        for (int k = 0; k < 4; k++) begin
            seed = xs(seed);
            s = {seed, ~seed, seed ^ 32'h5555_0000, seed + 32'd7};
            m = {~seed, seed, seed + 32'd3, seed ^ 32'hFFFF};
            run_op(s, m, 2'(k), 1'b1, "R4 R10 ignore start and code");
        end

        // R11: result held while idle inputs change.
        exp = state_out;
        @(negedge clk);
        state_in = ~state_in; msg_in = ~msg_in; func_sel = ~func_sel;
        repeat (3) @(negedge clk);
        chk(state_out == exp, "R11 hold", state_out, exp);

        // R1: reset in the middle of an operation.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 mid-run reset flags", {busy, done}, 0);
        chk(state_out == 0, "R1 mid-run reset state", state_out, 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule